// File: doc/BRIEF.md
# TDM Transmit Underrun Recovery Controller

This block sits between the per-time-slot transmit bit path of a multichannel time-division serial controller and the logic that fetches transmit buffers. In normal operation it passes the serial bit of the current time slot through unchanged and lets buffer fetches proceed. When a global transmit underrun is reported, it first forces a run of at least sixteen ones into every active slot. Each slot's ones are counted separately, on that slot's own bit times. It stops all buffer fetches and raises an underrun event.

Once a slot has sent its run of ones, it carries a fill pattern until recovery. Each channel's mode bit chooses the pattern: continuous ones, or a repeating flag byte. The controller returns to normal transmission only after the host has marked every channel's buffers ready and then issued a poll strobe. No other reinitialisation is needed. Time slot `i` is served by channel `i`.

Top module: `tdm_underrun_recovery`

## Requirements
- R1: After an underrun, each active slot outputs 1 on each of its first 16 strobed bit times. Only cycles with `bit_strobe` high and `slot_idx` equal to that slot count toward its 16.
- R2: An underrun seen while normal sets `underrun_event` on the next cycle, and it stays set until `event_ack`. `irq` equals `underrun_event` AND `irq_enable`.
- R3: `buf_fetch_en` is 1 in normal operation. It drops on the cycle after an underrun and stays 0 until recovery.
- R4: After its 16 ones, an active idle-mode slot (`flag_mode` bit 0) outputs 1. An active flag-mode slot (`flag_mode` bit 1) outputs the byte 0x7E least significant bit first (0,1,1,1,1,1,1,0), repeated. The pattern starts at its first bit at the underrun and advances only on that slot's own strobed fill bits.
- R5: Once every active slot has finished its ones, a poll with all `buf_ready` bits set returns the block to normal on the next cycle. `buf_fetch_en` then goes to 1 and `tx_bit` follows `data_bit_in`. A poll while any `buf_ready` bit is 0 is ignored.
- R6: A poll that arrives before every active slot has sent its 16 ones is ignored.
- R7: A slot whose `slot_active` bit is 0 outputs 1 during recovery and is not waited for at the end of the abort phase.
- R8: In normal operation `tx_bit` equals `data_bit_in`. A further underrun during recovery is ignored: the event is not set again and fill patterns continue without a new run of ones.
- R9: After reset the block is in normal operation with `buf_fetch_en` = 1, `underrun_event` = 0 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_idx | input | SLOT_W | Time slot currently on the line |
| bit_strobe | input | 1 | A bit of the current slot is sent this cycle |
| data_bit_in | input | 1 | Serial bit from the normal transmit path |
| slot_active | input | NUM_SLOTS | Per-slot enable |
| flag_mode | input | NUM_SLOTS | Per-channel fill choice: 1 selects flag, 0 selects idle |
| buf_ready | input | NUM_SLOTS | Host has re-armed that channel's transmit buffers |
| poll_strobe | input | 1 | Host poll command |
| underrun_in | input | 1 | Global transmit underrun detected |
| irq_enable | input | 1 | Interrupt enable for the underrun event |
| event_ack | input | 1 | Clears the underrun event |
| tx_bit | output | 1 | Serial bit sent on the line |
| buf_fetch_en | output | 1 | Buffer fetch permitted |
| underrun_event | output | 1 | Sticky underrun event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- a slot that has not finished its abort run is driven high;
- idle-mode slots stay high during fill;
- fetches stop and the event sets right after an underrun;
- the interrupt only rises while enabled;
- the fill state is left only on a poll with all channels ready, and a poll during abort is never accepted;
- a finished abort count is never lost.

Only the bench's scenarios can show the following:
- the exact flag bit order and that it advances only on its own slot's bits;
- that strobe-free cycles do not count;
- that a second underrun during recovery is ignored;
- that inactive slots release the abort phase early.

// File: rtl/tdm_urc_pkg.sv
package tdm_urc_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ABORT  = 2'd1,
        ST_FILL   = 2'd2
    } urc_state_e;

    typedef struct packed {
        urc_state_e st;
        logic       evt;
    } urc_ctl_t;

endpackage

// File: rtl/urc_abort_tracker.sv
module urc_abort_tracker #(
    parameter  int NUM_SLOTS  = 4,
    parameter  int ABORT_ONES = 16,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 count_en,
    input  logic [SLOT_W-1:0]    slot_idx,
    output logic [NUM_SLOTS-1:0] slot_done
);
    localparam int               CNT_W = $clog2(ABORT_ONES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ABORT_ONES);

    logic [CNT_W-1:0] cnt_d [NUM_SLOTS];
    logic [CNT_W-1:0] cnt_q [NUM_SLOTS];

    // Each slot counts only its own strobed bit times, saturating at LIMIT.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            cnt_d[i] = cnt_q[i];
            if (restart) begin
                cnt_d[i] = '0;
            end else if (count_en && (slot_idx == SLOT_W'(i)) && (cnt_q[i] != LIMIT)) begin
                cnt_d[i] = cnt_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) cnt_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_done
        assign slot_done[g] = (cnt_q[g] == LIMIT);

        AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_done[g] && !restart) |=> slot_done[g]); // R1
    end

endmodule

// File: rtl/urc_flag_phase.sv
module urc_flag_phase #(
    parameter  int         NUM_SLOTS = 4,
    parameter  logic [7:0] FLAG_BYTE = 8'h7E,
    localparam int         SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              adv_en,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic              flag_bit
);
    localparam int PH_W = 3;

    logic [PH_W-1:0] ph_d [NUM_SLOTS];
    logic [PH_W-1:0] ph_q [NUM_SLOTS];

    // Per-slot bit position within the flag byte, wrapping every eight bits.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            ph_d[i] = ph_q[i];
            if (restart) begin
                ph_d[i] = '0;
            end else if (adv_en && (slot_idx == SLOT_W'(i))) begin
                ph_d[i] = ph_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) ph_q[i] <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign flag_bit = FLAG_BYTE[ph_q[slot_idx]];

endmodule

// File: rtl/tdm_underrun_recovery.sv
module tdm_underrun_recovery
    import tdm_urc_pkg::*;
#(
    parameter  int         NUM_SLOTS  = 4,
    parameter  int         ABORT_ONES = 16,
    parameter  logic [7:0] FLAG_BYTE  = 8'h7E,
    localparam int         SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 bit_strobe,
    input  logic                 data_bit_in,
    input  logic [NUM_SLOTS-1:0] slot_active,
    input  logic [NUM_SLOTS-1:0] flag_mode,
    input  logic [NUM_SLOTS-1:0] buf_ready,
    input  logic                 poll_strobe,
    input  logic                 underrun_in,
    input  logic                 irq_enable,
    input  logic                 event_ack,
    output logic                 tx_bit,
    output logic                 buf_fetch_en,
    output logic                 underrun_event,
    output logic                 irq
);
    urc_ctl_t             ctl_d, ctl_q;
    logic [NUM_SLOTS-1:0] slot_done;
    logic                 restart;
    logic                 all_done;
    logic                 cur_active;
    logic                 cur_done;
    logic                 count_en;
    logic                 adv_en;
    logic                 flag_bit;
    logic                 poll_ok;

    assign cur_active = slot_active[slot_idx];
    assign cur_done   = slot_done[slot_idx];
    assign all_done   = &(slot_done | ~slot_active);
    assign poll_ok    = poll_strobe && (&buf_ready);
    assign restart    = (ctl_q.st == ST_NORMAL) && underrun_in;
    assign count_en   = bit_strobe && (ctl_q.st == ST_ABORT) && cur_active;
    assign adv_en     = bit_strobe && (ctl_q.st != ST_NORMAL) && cur_active
                        && cur_done && flag_mode[slot_idx];

    urc_abort_tracker #(
        .NUM_SLOTS (NUM_SLOTS),
        .ABORT_ONES(ABORT_ONES)
    ) u_abort (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .count_en (count_en),
        .slot_idx (slot_idx),
        .slot_done(slot_done)
    );

    urc_flag_phase #(
        .NUM_SLOTS(NUM_SLOTS),
        .FLAG_BYTE(FLAG_BYTE)
    ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .adv_en  (adv_en),
        .slot_idx(slot_idx),
        .flag_bit(flag_bit)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_NORMAL: if (underrun_in) ctl_d.st = ST_ABORT;
            ST_ABORT:  if (all_done)    ctl_d.st = ST_FILL;
            ST_FILL:   if (poll_ok)     ctl_d.st = ST_NORMAL;
            default:                    ctl_d.st = ST_NORMAL;
        endcase
        if (restart) begin
            ctl_d.evt = 1'b1;
        end else if (event_ack) begin
            ctl_d.evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_NORMAL, evt: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Serial output mux: data in normal, ones during abort, fill afterwards.
    always_comb begin
        if (ctl_q.st == ST_NORMAL) begin
            tx_bit = data_bit_in;
        end else if (!cur_active || !cur_done) begin
            tx_bit = 1'b1;
        end else if (flag_mode[slot_idx]) begin
            tx_bit = flag_bit;
        end else begin
            tx_bit = 1'b1;
        end
    end

    assign buf_fetch_en   = (ctl_q.st == ST_NORMAL);
    assign underrun_event = ctl_q.evt;
    assign irq            = ctl_q.evt && irq_enable;

    AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_ABORT) && cur_active && !cur_done) |-> tx_bit); // R1
    AST_EVENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> underrun_event); // R2
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_enable); // R2
    AST_FETCH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !buf_fetch_en); // R3
    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_FILL) && cur_active && !flag_mode[slot_idx]) |-> tx_bit); // R4
    AST_POLL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_FILL) && !poll_ok) |=> !buf_fetch_en); // R5
    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ABORT) |=> !buf_fetch_en); // R6

endmodule

// File: tb/tdm_underrun_recovery_test.sv
`timescale 1ns/1ps
module tdm_underrun_recovery_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   slot_idx = '0;
    logic         bit_strobe = 1'b0;
    logic         data_bit_in = 1'b0;
    logic [N-1:0] slot_active = 4'hF;
    logic [N-1:0] flag_mode = 4'b1010;
    logic [N-1:0] buf_ready = '0;
    logic         poll_strobe = 1'b0;
    logic         underrun_in = 1'b0;
    logic         irq_enable = 1'b1;
    logic         event_ack = 1'b0;
    logic         tx_bit, buf_fetch_en, underrun_event, irq;

    int checks = 0;
    int failures = 0;
    int recov = 0;
    int cnt [N];
    int ph [N];

    // {slot[1:0], data, expected} for normal-mode pass-through
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0011, 4'b0100, 4'b0111,
        4'b1011, 4'b1100, 4'b1111, 4'b0011
    };

    tdm_underrun_recovery uut (
        .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .bit_strobe(bit_strobe),
        .data_bit_in(data_bit_in), .slot_active(slot_active), .flag_mode(flag_mode),
        .buf_ready(buf_ready), .poll_strobe(poll_strobe), .underrun_in(underrun_in),
        .irq_enable(irq_enable), .event_ack(event_ack), .tx_bit(tx_bit),
        .buf_fetch_en(buf_fetch_en), .underrun_event(underrun_event), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_bit(input int s, input logic d);
        logic pat [8] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
        if (recov == 0) return d;
        if (!slot_active[s]) return 1'b1;
        if (cnt[s] < 16) begin
            cnt[s]++;
            return 1'b1;
        end
        if (flag_mode[s]) begin
            model_bit = pat[ph[s]];
            ph[s] = (ph[s] + 1) % 8;
            return model_bit;
        end
        return 1'b1;
    endfunction

    task automatic send_bit(input int s, input logic d, input string req);
        logic e;
        slot_idx = 2'(s);
        data_bit_in = d;
        bit_strobe = 1'b1;
        #1;
        e = model_bit(s, d);
        chk(req, tx_bit, e);
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        bit_strobe = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_underrun();
        underrun_in = 1'b1;
        @(negedge clk);
        underrun_in = 1'b0;
    endtask

    task automatic pulse_poll(input logic [N-1:0] rdy);
        buf_ready = rdy;
        poll_strobe = 1'b1;
        @(negedge clk);
        poll_strobe = 1'b0;
        #1;
    endtask

    task automatic frame(input int nslots, input logic d, input string req);
        for (int s = 0; s < nslots; s++)
            for (int b = 0; b < 8; b++) send_bit(s, d, req);
    endtask

    task automatic model_restart();
        recov = 1;
        for (int i = 0; i < N; i++) begin
            cnt[i] = 0;
            ph[i] = 0;
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin cnt[i] = 0; ph[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        chk("R9 fetch after reset", buf_fetch_en, 1'b1);
        chk("R9 event after reset", underrun_event, 1'b0);
        chk("R9 irq after reset", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            slot_idx = VEC[v][3:2];
            data_bit_in = VEC[v][1];
            bit_strobe = 1'b1;
            #1;
            chk("R8 normal pass-through", tx_bit, VEC[v][0]);
            @(negedge clk);
        end
        bit_strobe = 1'b0;
        chk("R3 fetch in normal", buf_fetch_en, 1'b1);

        // First underrun, interrupt enabled
        pulse_underrun();
        model_restart();
        #1;
        chk("R3 fetch stopped", buf_fetch_en, 1'b0);
        chk("R2 event set", underrun_event, 1'b1);
        chk("R2 irq with enable", irq, 1'b1);
        @(negedge clk);

        frame(N, 1'b0, "R1 abort ones frame 1");
        idle(5);  // no strobes: counts must not move
        pulse_poll(4'hF);
        chk("R6 poll during abort ignored", buf_fetch_en, 1'b0);
        buf_ready = '0;
        @(negedge clk);
        frame(N, 1'b0, "R1 abort ones frame 2");
        frame(N, 1'b0, "R4 fill patterns frame 3");
        send_bit(3, 1'b0, "R4 flag slot partial");
        send_bit(3, 1'b0, "R4 flag slot partial");
        send_bit(0, 1'b0, "R4 idle slot");

        event_ack = 1'b1;
        @(negedge clk);
        event_ack = 1'b0;
        #1;
        chk("R2 event cleared by ack", underrun_event, 1'b0);
        chk("R2 irq cleared by ack", irq, 1'b0);
        @(negedge clk);

        pulse_underrun();
        #1;
        chk("R8 underrun in fill no event", underrun_event, 1'b0);
        @(negedge clk);
        frame(N, 1'b0, "R8 fill continues after second underrun");

        pulse_poll(4'b1011);
        chk("R5 poll with channel not ready ignored", buf_fetch_en, 1'b0);
        @(negedge clk);
        send_bit(1, 1'b0, "R5 still fill after bad poll");
        pulse_poll(4'hF);
        chk("R5 recovered fetch", buf_fetch_en, 1'b1);
        recov = 0;
        @(negedge clk);
        send_bit(2, 1'b0, "R5 data after recovery");
        send_bit(1, 1'b1, "R5 data after recovery");

        // Second underrun: interrupt disabled, slot 3 inactive
        irq_enable = 1'b0;
        slot_active = 4'b0111;
        buf_ready = '0;
        pulse_underrun();
        model_restart();
        #1;
        chk("R2 event set without enable", underrun_event, 1'b1);
        chk("R2 irq masked", irq, 1'b0);
        @(negedge clk);
        send_bit(3, 1'b0, "R7 inactive slot sends one");
        frame(3, 1'b0, "R1 abort three active slots a");
        frame(3, 1'b0, "R1 abort three active slots b");
        idle(2);
        pulse_poll(4'hF);
        chk("R7 recovery without inactive slot", buf_fetch_en, 1'b1);
        recov = 0;
        @(negedge clk);
        send_bit(3, 1'b0, "R8 inactive slot data after recovery");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule